// File: doc/BRIEF.md
# Round-Robin Packet Bus Fabric

The block joins a set of processor nodes over one shared packet bus. Every node owns a network interface made of two flit queues: a transmit queue that the processor fills through a write port, and a receive queue that the processor empties through a read port. Each side shows its fill state as a status word (free slots on the transmit side, occupied slots on the receive side). The processor polls that status before it writes a flit.

A central controller lets exactly one node own the bus at a time. It chooses among the nodes whose transmit queue is not empty in fair round-robin order, and it keeps the grant until the whole packet has moved. A packet starts with two header flits. The first header flit is the target flit: its low byte names the destination node and its high byte is not used for routing. The second header flit is the count of body flits that follow. All flits, headers included, are copied in order into the destination's receive queue.

The controller is a four-state machine:
- IDLE goes to TARGET when the arbiter grants a node.
- TARGET moves the target flit and then goes to COUNT.
- COUNT moves the count flit. It returns to IDLE when the count is zero and goes to BODY otherwise.
- BODY moves body flits and returns to IDLE after the last one.

Any state other than IDLE waits in place while the source queue is empty, or while the destination queue is full. A target index with no attached node sets a sticky error flag, and the whole packet is drained and thrown away.

Top module: `pktbus_top`

## Requirements
- R1: After reset every `tx_free` field equals DEPTH (8), every `rx_used` field is 0 and `cfg_err` is 0.
- R2: A write to a node whose transmit queue has free space lowers that node's `tx_free` by one on the next clock edge. A write while `tx_free` is 0 is ignored: the flit is lost and the status does not change.
- R3: The packet's flits appear in the receive queue of the node named by bits 7:0 of the target flit, in their original order, both header flits included. Bits 15:8 of the target flit do not affect routing.
- R4: The second flit gives the number of body flits. A count of 0 gives a packet of exactly two flits.
- R5: Only one source sends at a time. Once a packet has started, flits from other sources never interleave with it.
- R6: The search for the next grant starts at the node after the one whose packet completed last. After reset, the search starts at node 0.
- R7: While the destination receive queue is full, forwarding stalls and no flit is lost.
- R8: A target index of N_NODES or more sets `cfg_err`, which stays set until reset. That packet's flits are removed from the transmit queue and delivered nowhere.
- R9: A read pulse removes the head flit of the receive queue, which is shown on `rd_data`. A read pulse to an empty receive queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | N_NODES | Per-node flit write strobe |
| wr_data | input | N_NODES*16 | Per-node write flit, node i in bits 16i+15:16i |
| tx_free | output | N_NODES*CW | Per-node free transmit slots, CW = clog2(DEPTH+1) |
| rd_en | input | N_NODES | Per-node receive pop strobe |
| rd_data | output | N_NODES*16 | Per-node head of the receive queue |
| rx_used | output | N_NODES*CW | Per-node occupied receive slots |
| cfg_err | output | 1 | Sticky flag for a packet sent to a missing node |

## Verification
A write changes `tx_free` on the edge that takes it. The first flit of a packet entering an idle fabric leaves the transmit queue and shows in the receive queue two edges later: one edge to grant, one edge to move. After that the fabric moves one flit per edge whenever data and space are both present. The bench drives inputs and samples outputs on the falling edge. It checks the status words at exactly those edge counts for the first flit. For the rest of a packet it polls the status words, the same way the processor would, before it compares flit values. The arbitration order is worked out from the pointer rule and checked through the order in which whole packets arrive at a shared destination, with that destination held full so that stalls are exercised.

// File: rtl/pktbus_pkg.sv
package pktbus_pkg;
    localparam int FLIT_W = 16;
    localparam int ADDR_BITS = 8;

    typedef logic [FLIT_W-1:0] flit_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_TARGET,
        S_COUNT,
        S_BODY
    } bus_state_e;
endpackage

// File: rtl/pktbus_fifo.sv
module pktbus_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (int'(rptr) == DEPTH - 1) ? '0 : rptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R2: a write offered to a full queue leaves the fill level untouched
    a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)));

    // R9: a read of an empty queue leaves it empty
    a_r9_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0));
endmodule

// File: rtl/pktbus_rr_arb.sv
module pktbus_rr_arb #(
    parameter int N  = 4,
    parameter int NW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    input  logic [NW-1:0] last,
    output logic [NW-1:0] gnt_idx,
    output logic          gnt_any
);
    logic [NW-1:0] ptr;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            int k;
            k = (int'(ptr) + i) % N;
            if (!gnt_any && req[k]) begin
                gnt_any = 1'b1;
                gnt_idx = NW'(k);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (int'(last) == N - 1) ? '0 : last + 1'b1;
        end
    end

    // R6: the node under the pointer wins whenever it asks
    a_r6_pointer_first: assert property (@(posedge clk) disable iff (!rst_n)
        req[ptr] |-> (gnt_any && gnt_idx == ptr));

    // R6: a grant always lands on a requesting node
    a_r6_grant_requests: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> req[gnt_idx]);
endmodule

// File: rtl/pktbus_ctrl.sv
module pktbus_ctrl
    import pktbus_pkg::*;
#(
    parameter int N  = 4,
    parameter int NW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0]         gnt_idx,
    input  logic                  gnt_any,
    input  logic [N-1:0]          tx_empty,
    input  logic [N-1:0][FLIT_W-1:0] tx_head,
    input  logic [N-1:0]          rx_full,
    output logic [N-1:0]          tx_pop,
    output logic [N-1:0]          rx_push,
    output flit_t                 fwd_data,
    output logic                  pkt_done,
    output logic [NW-1:0]         done_src,
    output logic                  cfg_err
);
    bus_state_e    state, state_nx;
    logic [NW-1:0] src_q, dst_q, cur_dst;
    logic          bad_q, cur_bad, bad_now;
    flit_t         remain, head;
    logic          xfer;

    assign head     = tx_head[src_q];
    assign bad_now  = (int'(head[ADDR_BITS-1:0]) >= N);
    assign done_src = src_q;
    assign fwd_data = head;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs: transfer decision and queue strobes
    always_comb begin
        cur_dst  = (state == S_TARGET) ? head[NW-1:0] : dst_q;
        cur_bad  = (state == S_TARGET) ? bad_now : bad_q;
        xfer     = (state != S_IDLE) && !tx_empty[src_q] && (cur_bad || !rx_full[cur_dst]);
        tx_pop   = '0;
        rx_push  = '0;
        if (xfer) begin
            tx_pop[src_q] = 1'b1;
            if (!cur_bad) begin
                rx_push[cur_dst] = 1'b1;
            end
        end
        pkt_done = xfer && (((state == S_COUNT) && (head == '0)) ||
                            ((state == S_BODY) && (remain == flit_t'(1))));
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (gnt_any) state_nx = S_TARGET;
            S_TARGET: if (xfer) state_nx = S_COUNT;
            S_COUNT:  if (xfer) state_nx = (head == '0) ? S_IDLE : S_BODY;
            S_BODY:   if (xfer && remain == flit_t'(1)) state_nx = S_IDLE;
        endcase
    end

    // packet bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            bad_q   <= 1'b0;
            remain  <= '0;
            cfg_err <= 1'b0;
        end else begin
            if (state == S_IDLE && gnt_any) begin
                src_q <= gnt_idx;
            end
            if (state == S_TARGET && xfer) begin
                dst_q <= head[NW-1:0];
                bad_q <= bad_now;
                if (bad_now) begin
                    cfg_err <= 1'b1;
                end
            end
            if (state == S_COUNT && xfer) begin
                remain <= head;
            end
            if (state == S_BODY && xfer) begin
                remain <= remain - 1'b1;
            end
        end
    end

    // R5: at most one transmit queue drains per cycle
    a_r5_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_pop));

    // R5: the source stays fixed while a packet is in flight
    a_r5_source_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> (state == S_IDLE || src_q == $past(src_q)));

    // R7: nothing is pushed into a full receive queue
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push & rx_full) == '0);

    // R4: a zero count ends the packet after the count flit
    a_r4_zero_count_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COUNT && xfer && head == '0) |=> (state == S_IDLE));

    // R8: the error flag never clears once set
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R8: a discarded packet reaches no receive queue
    a_r8_bad_no_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_TARGET && bad_q) |-> (rx_push == '0));
endmodule

// File: rtl/pktbus_top.sv
module pktbus_top
    import pktbus_pkg::*;
#(
    parameter int N_NODES = 4,
    parameter int DEPTH   = 8,
    localparam int NW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_NODES-1:0]        wr_en,
    input  logic [N_NODES*FLIT_W-1:0] wr_data,
    output logic [N_NODES*CW-1:0]     tx_free,
    input  logic [N_NODES-1:0]        rd_en,
    output logic [N_NODES*FLIT_W-1:0] rd_data,
    output logic [N_NODES*CW-1:0]     rx_used,
    output logic                      cfg_err
);
    logic [N_NODES-1:0]             tx_empty, tx_full_unused, tx_pop;
    logic [N_NODES-1:0]             rx_full, rx_empty_unused, rx_push;
    logic [N_NODES-1:0][FLIT_W-1:0] tx_head;
    flit_t                          fwd_data;
    logic [NW-1:0]                  gnt_idx, done_src;
    logic                           gnt_any, pkt_done;

    for (genvar g = 0; g < N_NODES; g++) begin : g_node
        logic [CW-1:0] tx_level;

        pktbus_fifo #(.DEPTH(DEPTH), .WIDTH(FLIT_W)) u_tx (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr_en[g]),
            .push_data (wr_data[g*FLIT_W +: FLIT_W]),
            .pop       (tx_pop[g]),
            .head      (tx_head[g]),
            .full      (tx_full_unused[g]),
            .empty     (tx_empty[g]),
            .level     (tx_level)
        );
        assign tx_free[g*CW +: CW] = CW'(DEPTH) - tx_level;

        pktbus_fifo #(.DEPTH(DEPTH), .WIDTH(FLIT_W)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (rx_push[g]),
            .push_data (fwd_data),
            .pop       (rd_en[g]),
            .head      (rd_data[g*FLIT_W +: FLIT_W]),
            .full      (rx_full[g]),
            .empty     (rx_empty_unused[g]),
            .level     (rx_used[g*CW +: CW])
        );
    end

    pktbus_rr_arb #(.N(N_NODES), .NW(NW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (~tx_empty),
        .adv     (pkt_done),
        .last    (done_src),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    pktbus_ctrl #(.N(N_NODES), .NW(NW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt_idx  (gnt_idx),
        .gnt_any  (gnt_any),
        .tx_empty (tx_empty),
        .tx_head  (tx_head),
        .rx_full  (rx_full),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .fwd_data (fwd_data),
        .pkt_done (pkt_done),
        .done_src (done_src),
        .cfg_err  (cfg_err)
    );
endmodule

// File: tb/sim_pktbus_top.sv
`timescale 1ns/1ps
module sim_pktbus_top;
    localparam int N  = 4;
    localparam int D  = 8;
    localparam int CW = 4;
    localparam int FW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    wr_en, rd_en;
    logic [N*FW-1:0] wr_data, rd_data;
    logic [N*CW-1:0] tx_free, rx_used;
    logic            cfg_err;

    logic          bw_en  [N];
    logic [FW-1:0] bw_dat [N];
    logic          br_en  [N];

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            wr_en[i]            = bw_en[i];
            wr_data[i*FW +: FW] = bw_dat[i];
            rd_en[i]            = br_en[i];
        end
    end

    pktbus_top #(.N_NODES(N), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_free(tx_free),
        .rd_en(rd_en), .rd_data(rd_data), .rx_used(rx_used), .cfg_err(cfg_err)
    );

    function automatic int txf(int n); return int'(tx_free[n*CW +: CW]); endfunction
    function automatic int rxu(int n); return int'(rx_used[n*CW +: CW]); endfunction
    function automatic int rdd(int n); return int'(rd_data[n*FW +: FW]); endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(int n, int v);
        @(negedge clk);
        while (txf(n) == 0) @(negedge clk);
        bw_en[n]  = 1'b1;
        bw_dat[n] = FW'(v);
        @(negedge clk);
        bw_en[n]  = 1'b0;
    endtask

    task automatic send(int src, int tgt, int len, int tag);
        put(src, tgt);
        put(src, len);
        for (int k = 0; k < len; k++) put(src, (tag << 8) | k);
    endtask

    task automatic take(int n, int v, string tag);
        @(negedge clk);
        while (rxu(n) == 0) @(negedge clk);
        chk(tag, rdd(n), v);
        br_en[n] = 1'b1;
        @(negedge clk);
        br_en[n] = 1'b0;
    endtask

    task automatic take_pkt(int n, int tgt, int len, int tag, string req);
        take(n, tgt, req);
        take(n, len, req);
        for (int k = 0; k < len; k++) take(n, (tag << 8) | k, req);
    endtask

    task automatic idle(int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            bw_en[i] = 1'b0; bw_dat[i] = '0; br_en[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int n = 0; n < N; n++) begin
            chk("R1 tx_free", txf(n), D);
            chk("R1 rx_used", rxu(n), 0);
        end
        chk("R1 cfg_err", int'(cfg_err), 0);

        // R2 status timing, R3 first-flit timing into node 2
        bw_en[0] = 1'b1; bw_dat[0] = 16'h0002;
        @(negedge clk);
        bw_en[0] = 1'b0;
        chk("R2 tx_free after write", txf(0), D - 1);
        @(negedge clk);
        chk("R3 grant edge, not yet moved", txf(0), D - 1);
        @(negedge clk);
        chk("R3 target flit left tx", txf(0), D);
        chk("R3 target flit in rx", rxu(2), 1);
        put(0, 1);
        put(0, 16'h0A00);
        take_pkt(2, 2, 1, 8'h0A, "R3 first packet");

        // R4 zero-length packet
        send(1, 0, 0, 0);
        take_pkt(0, 0, 0, 0, "R4 zero count");
        idle(6);
        chk("R4 only two flits", rxu(0), 0);
        chk("R4 tx drained", txf(1), D);

        // R3 upper byte of target ignored
        send(3, 16'hAB01, 2, 8'h3B);
        take_pkt(1, 16'hAB01, 2, 8'h3B, "R3 upper byte ignored");

        // R3 sweep over every source/destination pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                send(s, d, (s + d) % 3, 8'h40 + s * 4 + d);
                take_pkt(d, d, (s + d) % 3, 8'h40 + s * 4 + d, "R3 sweep");
            end
        end

        // R6 set pointer: node 1 alone, pointer moves to node 2
        send(1, 3, 2, 8'h11);
        take_pkt(3, 3, 2, 8'h11, "R6 lone packet");

        // R5 R6 R7 three contenders for node 3, 12 flits into 8 slots
        fork
            send(0, 3, 2, 8'h20);
            send(1, 3, 2, 8'h21);
            send(2, 3, 2, 8'h22);
        join
        idle(40);
        chk("R7 rx held full", rxu(3), D);
        chk("R7 remaining flits kept", txf(0) + txf(1) + txf(2), 3 * D - 4);
        take_pkt(3, 3, 2, 8'h22, "R6 order first node 2");
        take_pkt(3, 3, 2, 8'h20, "R6 order then node 0");
        take_pkt(3, 3, 2, 8'h21, "R5 R6 order then node 1");

        // R8 missing target
        chk("R8 no error yet", int'(cfg_err), 0);
        send(0, 16'h0007, 2, 8'h70);
        idle(20);
        chk("R8 error set", int'(cfg_err), 1);
        chk("R8 packet drained", txf(0), D);
        for (int n = 0; n < N; n++) chk("R8 nothing delivered", rxu(n), 0);
        send(1, 2, 1, 8'h71);
        take_pkt(2, 2, 1, 8'h71, "R8 fabric continues");
        chk("R8 error sticky", int'(cfg_err), 1);

        // R2 write into a full transmit queue
        put(0, 1);
        put(0, 20);
        for (int k = 0; k < 14; k++) put(0, (8'h55 << 8) | k);
        idle(10);
        chk("R2 tx full", txf(0), 0);
        chk("R7 rx full", rxu(1), D);
        bw_en[0] = 1'b1; bw_dat[0] = 16'hDEAD;
        @(negedge clk);
        bw_en[0] = 1'b0;
        chk("R2 full write ignored", txf(0), 0);
        fork
            for (int k = 14; k < 20; k++) put(0, (8'h55 << 8) | k);
            take_pkt(1, 1, 20, 8'h55, "R2 R7 long packet without extra flit");
        join
        idle(6);
        chk("R2 no extra flit", rxu(1), 0);

        // R9 read of an empty queue
        br_en[1] = 1'b1;
        @(negedge clk);
        br_en[1] = 1'b0;
        chk("R9 empty read ignored", rxu(1), 0);
        send(2, 1, 1, 8'h91);
        take_pkt(1, 1, 1, 8'h91, "R9 queue intact");

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule